// File: doc/BRIEF.md
# Register-Write Command Queue Engine

This block is a hardware sequencer that walks a ring of 8-byte entries held in system memory and carries each one out as a single 32-bit register write. Every entry holds a destination address in its lower word and a data value in its upper word. The engine reads an entry through a simple memory read port, advances its fetch pointer by eight bytes, and then sends the write out through a simple write port. Software fills the ring, programs a small register file, and lets the engine run without further help.

Two destination addresses are treated as the engine's own registers and are never sent to the write port. A write to the fetch-address register makes the engine jump, which is how a ring wraps or loops. A write to the current-index register reports progress. With pause-on-match enabled, the engine holds at an entry boundary whenever the current index equals the end index. Software then advances the end index to release the next batch. Bit 0 of an entry's address asks for an update pulse once the entry has completed. An external pause input, the enable bit and the error flag also stop the engine, always at an entry boundary.

Top module: `cmdq_engine`

## Requirements
- R1: An entry is 64 bits read from the fetch address: bits [31:0] are the destination and bits [63:32] the value. The engine writes the value to the destination through the write port, in ring order, and each fetch moves the fetch address up by 8. The write port holds its address and data steady until it is acknowledged.
- R2: When bit 0 of an entry's destination is set, the write goes out with bit 0 cleared. One cycle after the entry completes, `upd_irq` pulses high for exactly one cycle and sets the sticky pending bit (status bit 3). Writing 1 to status bit 3 clears the pending bit.
- R3: An entry whose destination, with bit 0 cleared, equals `SELF_FADDR` loads the fetch address with its value. No external write is issued, and the next fetch comes from the new address.
- R4: An entry whose destination, with bit 0 cleared, equals `SELF_CIDX` loads the 8-bit current index (select 2) from the low bits of its value. No external write is issued.
- R5: While pause-on-match (select 4, bit 0) is set and the current index equals the end index (select 3), the engine starts no fetch. Writing a new end index lets it continue.
- R6: The config register (select 0) holds enable in bit 0 and a 3-bit priority in bits [3:1], and both read back as written. Clearing enable stops the engine after the entry in flight, and the fetch address stays on that entry boundary. Setting enable again resumes from there.
- R7: Status (select 5) reads bit 0 as transfer in progress, bit 1 as error, bit 2 as paused and bit 3 as pending. After reset all four bits read 0, as do the fetch address and both indices. Paused means enabled, idle, no error and a pause condition present.
- R8: While the engine is paused or disabled, software may rewrite the fetch address (select 1). Execution then resumes from the new address.
- R9: While `pause_req` is high, no new entry is fetched, and status shows paused. When it drops, execution continues.
- R10: An error on the fetch port (the entry is not consumed and the fetch address is unchanged) or on the write port (the entry counts as consumed) sets the error flag and halts the engine. Writing 1 to status bit 1 clears the flag, and the engine resumes once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 config, 1 fetch address, 2 current index, 3 end index, 4 pause enable, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| pause_req | input | 1 | External pause request, taken at entry boundaries |
| fetch_req | output | 1 | Entry fetch request, held until `fetch_valid` |
| fetch_addr | output | 32 | Byte address of the entry being fetched |
| fetch_valid | input | 1 | Fetch response valid |
| fetch_rdata | input | 64 | Fetched entry: destination in [31:0], value in [63:32] |
| fetch_err | input | 1 | Fetch error, qualified by `fetch_valid` |
| wr_req | output | 1 | Register write request, held until `wr_ack` |
| wr_addr | output | 32 | Write destination, bit 0 cleared |
| wr_data | output | 32 | Write value |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, qualified by `wr_ack` |
| upd_irq | output | 1 | One-cycle update pulse |

## Verification
On every cycle the assertions check four things. The write port holds its request steady and never carries an odd address or one of the engine's own register addresses. A fetch starts only when the engine was enabled, free of error and not paused. An error freezes the fetch side. Every update pulse lasts one cycle and leaves the pending bit set. Some behaviour shows only in the bench's scenarios: the exact order and content of the writes, where jumps land, the index the engine stops on, and the boundary reached after a disable or a fault. The bench checks these against lists and addresses it computes from the entries it plants in its memory model.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} cq_state_e;
  typedef enum logic [1:0] {TGT_EXT, TGT_FADDR, TGT_CIDX} cq_tgt_e;

  localparam logic [2:0] SEL_CFG   = 3'd0;
  localparam logic [2:0] SEL_FADDR = 3'd1;
  localparam logic [2:0] SEL_CIDX  = 3'd2;
  localparam logic [2:0] SEL_EIDX  = 3'd3;
  localparam logic [2:0] SEL_PCFG  = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;

  localparam int unsigned STB_TIP  = 0;
  localparam int unsigned STB_ERR  = 1;
  localparam int unsigned STB_PAUS = 2;
  localparam int unsigned STB_PEND = 3;

  localparam logic [31:0] ENTRY_BYTES = 32'd8;

  function automatic logic [31:0] strip_flag(input logic [31:0] a);
    return {a[31:1], 1'b0};
  endfunction

  function automatic logic [31:0] next_fetch(input logic [31:0] a);
    return a + ENTRY_BYTES;
  endfunction

  function automatic cq_tgt_e classify(input logic [31:0] a,
                                       input logic [31:0] self_faddr,
                                       input logic [31:0] self_cidx);
    if (strip_flag(a) == self_faddr) return TGT_FADDR;
    if (strip_flag(a) == self_cidx)  return TGT_CIDX;
    return TGT_EXT;
  endfunction
endpackage

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter logic [31:0] SELF_FADDR = 32'hF000_0004,
  parameter logic [31:0] SELF_CIDX  = 32'hF000_0008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  output logic        fetch_req,
  input  logic        fetch_valid,
  input  logic [63:0] fetch_rdata,
  input  logic        fetch_err,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_ack,
  input  logic        wr_err,
  output logic        busy,
  output logic        faddr_inc,
  output logic        faddr_ld,
  output logic        cidx_ld,
  output logic [31:0] ld_val,
  output logic        err_set,
  output logic        irq_pulse
);
  cq_state_e   state_q, state_d;
  logic [31:0] ent_addr_q, ent_val_q;
  cq_tgt_e     tgt;
  logic        entry_done;

  assign tgt     = classify(ent_addr_q, SELF_FADDR, SELF_CIDX);
  assign wr_addr = strip_flag(ent_addr_q);
  assign wr_data = ent_val_q;
  assign ld_val  = ent_val_q;
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_d    = state_q;
    fetch_req  = 1'b0;
    wr_req     = 1'b0;
    faddr_inc  = 1'b0;
    faddr_ld   = 1'b0;
    cidx_ld    = 1'b0;
    err_set    = 1'b0;
    entry_done = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_FETCH;
      ST_FETCH: begin
        fetch_req = 1'b1;
        if (fetch_valid) begin
          if (fetch_err) begin
            err_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            faddr_inc = 1'b1;
            state_d   = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        unique case (tgt)
          TGT_FADDR: begin
            faddr_ld   = 1'b1;
            entry_done = 1'b1;
          end
          TGT_CIDX: begin
            cidx_ld    = 1'b1;
            entry_done = 1'b1;
          end
          default: begin
            wr_req = 1'b1;
            if (wr_ack) begin
              err_set    = wr_err;
              entry_done = !wr_err;
            end
          end
        endcase
        if (entry_done || err_set) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ent_addr_q <= '0;
      ent_val_q  <= '0;
      irq_pulse  <= 1'b0;
    end else begin
      state_q   <= state_d;
      irq_pulse <= entry_done && ent_addr_q[0];
      if (faddr_inc) begin
        ent_addr_q <= fetch_rdata[31:0];
        ent_val_q  <= fetch_rdata[63:32];
      end
    end
  end
endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pause_req,
  input  logic        busy,
  input  logic        faddr_inc,
  input  logic        faddr_ld,
  input  logic        cidx_ld,
  input  logic [31:0] ld_val,
  input  logic        err_set,
  input  logic        irq_pulse,
  output logic [31:0] faddr,
  output logic        cfg_en,
  output logic        err_q,
  output logic        pend_q,
  output logic        pause_hit
);
  localparam int unsigned CFG_W = PRIO_W + 1;

  logic [CFG_W-1:0] cfg_q;
  logic [IDX_W-1:0] cidx_q, eidx_q;
  logic             pen_q;
  logic             paused;
  logic             wr_stat;

  assign cfg_en    = cfg_q[0];
  assign pause_hit = (pen_q && (cidx_q == eidx_q)) || pause_req;
  assign paused    = cfg_en && !busy && !err_q && pause_hit;
  assign wr_stat   = reg_wr && (reg_sel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      faddr  <= '0;
      cidx_q <= '0;
      eidx_q <= '0;
      pen_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_CFG)  cfg_q  <= reg_wdata[CFG_W-1:0];
      if (reg_wr && reg_sel == SEL_EIDX) eidx_q <= reg_wdata[IDX_W-1:0];
      if (reg_wr && reg_sel == SEL_PCFG) pen_q  <= reg_wdata[0];
      if (faddr_ld)                          faddr <= ld_val;
      else if (faddr_inc)                    faddr <= next_fetch(faddr);
      else if (reg_wr && reg_sel == SEL_FADDR) faddr <= reg_wdata;
      if (cidx_ld)                           cidx_q <= ld_val[IDX_W-1:0];
      else if (reg_wr && reg_sel == SEL_CIDX) cidx_q <= reg_wdata[IDX_W-1:0];
      err_q  <= err_set   || (err_q  && !(wr_stat && reg_wdata[STB_ERR]));
      pend_q <= irq_pulse || (pend_q && !(wr_stat && reg_wdata[STB_PEND]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CFG:   reg_rdata[CFG_W-1:0] = cfg_q;
      SEL_FADDR: reg_rdata = faddr;
      SEL_CIDX:  reg_rdata[IDX_W-1:0] = cidx_q;
      SEL_EIDX:  reg_rdata[IDX_W-1:0] = eidx_q;
      SEL_PCFG:  reg_rdata[0] = pen_q;
      SEL_STAT: begin
        reg_rdata[STB_TIP]  = busy;
        reg_rdata[STB_ERR]  = err_q;
        reg_rdata[STB_PAUS] = paused;
        reg_rdata[STB_PEND] = pend_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned PRIO_W     = 3,
  parameter logic [31:0] SELF_FADDR = 32'hF000_0004,
  parameter logic [31:0] SELF_CIDX  = 32'hF000_0008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pause_req,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        fetch_valid,
  input  logic [63:0] fetch_rdata,
  input  logic        fetch_err,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_ack,
  input  logic        wr_err,
  output logic        upd_irq
);
  logic        busy, faddr_inc, faddr_ld, cidx_ld, err_set, irq_pulse;
  logic [31:0] ld_val;
  logic        cfg_en, err_q, pend_q, pause_hit, go;

  assign go      = cfg_en && !err_q && !pause_hit;
  assign upd_irq = irq_pulse;

  cmdq_regs #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pause_req(pause_req),
    .busy(busy), .faddr_inc(faddr_inc), .faddr_ld(faddr_ld),
    .cidx_ld(cidx_ld), .ld_val(ld_val), .err_set(err_set),
    .irq_pulse(irq_pulse), .faddr(fetch_addr), .cfg_en(cfg_en),
    .err_q(err_q), .pend_q(pend_q), .pause_hit(pause_hit)
  );

  cmdq_seq #(.SELF_FADDR(SELF_FADDR), .SELF_CIDX(SELF_CIDX)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fetch_req(fetch_req),
    .fetch_valid(fetch_valid), .fetch_rdata(fetch_rdata),
    .fetch_err(fetch_err), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err), .busy(busy),
    .faddr_inc(faddr_inc), .faddr_ld(faddr_ld), .cidx_ld(cidx_ld),
    .ld_val(ld_val), .err_set(err_set), .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter logic [31:0] SELF_FADDR = 32'hF000_0004,
  parameter logic [31:0] SELF_CIDX  = 32'hF000_0008
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        upd_irq,
  input logic        cfg_en,
  input logic        err_q,
  input logic        pend_q,
  input logic        pause_hit
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R1
  AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !wr_addr[0]); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |=> !upd_irq); // R2
  AST_IRQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |=> pend_q); // R2
  AST_NO_SELF_FADDR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr != SELF_FADDR); // R3
  AST_NO_SELF_CIDX_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr != SELF_CIDX); // R4
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(cfg_en && !err_q && !pause_hit)); // R5
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !fetch_req |=> !fetch_req); // R10
endmodule

bind cmdq_engine cmdq_engine_chk #(.SELF_FADDR(SELF_FADDR), .SELF_CIDX(SELF_CIDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .wr_req(wr_req),
  .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data), .upd_irq(upd_irq),
  .cfg_en(cfg_en), .err_q(err_q), .pend_q(pend_q), .pause_hit(pause_hit)
);

// File: tb/cmdq_engine_tb.sv
module cmdq_engine_tb;
  localparam logic [31:0] SF = 32'hF000_0004;
  localparam logic [31:0] SC = 32'hF000_0008;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pause_req = 1'b0;
  logic        fetch_req, fetch_valid = 1'b0, fetch_err = 1'b0;
  logic [31:0] fetch_addr;
  logic [63:0] fetch_rdata = '0;
  logic        wr_req, wr_ack = 1'b0, wr_err = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        upd_irq;

  cmdq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pause_req(pause_req),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_rdata(fetch_rdata), .fetch_err(fetch_err), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
    .upd_irq(upd_irq)
  );

  always #4 clk = ~clk;

  int unsigned n_chk = 0, n_bad = 0;
  logic [63:0] mem [64];
  logic [31:0] bad_faddr = 32'hFFFF_FFF0;
  logic [31:0] bad_waddr = 32'hFFFF_FFF0;
  logic [31:0] exp_a [256], exp_d [256], obs_a [256], obs_d [256];
  int unsigned exp_n = 0, obs_n = 0, irq_n = 0, exp_irq = 0;
  int unsigned idx = 0;

  // Memory model and write target, driven away from the active edge
  always @(negedge clk) begin
    fetch_valid = fetch_req && ($urandom % 3 != 0);
    fetch_rdata = mem[fetch_addr[8:3]];
    fetch_err   = fetch_valid && (fetch_addr == bad_faddr);
    wr_ack      = wr_req && ($urandom % 3 != 0);
    wr_err      = wr_ack && (wr_addr == bad_waddr);
    if (upd_irq) irq_n++;
  end

  always @(posedge clk)
    if (rst_n && wr_req && wr_ack && !wr_err) begin
      obs_a[obs_n] = wr_addr;
      obs_d[obs_n] = wr_data;
      obs_n++;
    end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wait_bit(input int b);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rreg(3'd5, v);
      if (v[b]) return;
    end
  endtask

  function automatic logic [63:0] ent(input logic [31:0] a, input logic [31:0] v);
    return {v, a};
  endfunction

  task automatic put_w(input int i, input logic [31:0] a, input logic [31:0] v, input bit expect_it);
    mem[i] = ent(a, v);
    if (expect_it) begin
      exp_a[exp_n] = {a[31:1], 1'b0};
      exp_d[exp_n] = v;
      exp_n++;
    end
    if (a[0]) exp_irq++;
  endtask

  task automatic check_log(input string req);
    check(obs_n == exp_n, req, obs_n, exp_n);
    for (int k = 0; k < 256; k++)
      if (k < exp_n && k < obs_n && (obs_a[k] != exp_a[k] || obs_d[k] != exp_d[k]))
        check(1'b0, req, obs_a[k] ^ obs_d[k], exp_a[k] ^ exp_d[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned ptr, cnt0, nent;
    void'($urandom(32'd7741));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state
    rreg(3'd5, v); check(v == 0, "R7 status reset", v, 0);
    rreg(3'd1, v); check(v == 0, "R7 faddr reset", v, 0);
    rreg(3'd2, v); check(v == 0, "R7 cidx reset", v, 0);

    // Config readback, pause on equal indices
    wreg(3'd0, 32'h0000_000A);
    rreg(3'd0, v); check(v == 32'hA, "R6 priority readback", v, 32'hA);
    wreg(3'd4, 1);
    wreg(3'd0, 32'h0000_000B);
    repeat (3) @(posedge clk);
    rreg(3'd5, v); check(v[2:0] == 3'b100, "R5 paused at equal index", v, 4);

    // Plain writes, flag bit stripped, index update
    put_w(0, 32'h0000_1000, 32'hA, 1);
    put_w(1, 32'h0000_1005, 32'hB, 1);
    put_w(2, SC, 1, 0);
    idx = 1; wreg(3'd3, idx);
    wait_bit(2);
    check_log("R1 write sequence");
    rreg(3'd2, v); check(v == 1, "R4 current index", v, 1);
    rreg(3'd1, v); check(v == 32'h18, "R1 fetch advance", v, 32'h18);
    check(irq_n == exp_irq, "R2 update pulses", irq_n, exp_irq);
    rreg(3'd5, v); check(v[3] == 1'b1, "R2 pending set", v, 8);
    wreg(3'd5, 32'h8);
    rreg(3'd5, v); check(v[3] == 1'b0, "R2 pending clear", v, 0);

    // Jump through own fetch-address register
    put_w(3, SF | 1, 32'h100, 0);
    put_w(32, 32'h0000_1010, 32'hC, 1);
    put_w(33, SC, 2, 0);
    idx = 2; wreg(3'd3, idx);
    wait_bit(2);
    check_log("R3 jump writes");
    rreg(3'd1, v); check(v == 32'h110, "R3 jump target", v, 32'h110);
    check(irq_n == exp_irq, "R3 jump pulse", irq_n, exp_irq);

    // Software moves the fetch address while paused
    put_w(40, 32'h0000_1020, 32'hD, 1);
    put_w(41, SC, 3, 0);
    wreg(3'd1, 32'h140);
    idx = 3; wreg(3'd3, idx);
    wait_bit(2);
    check_log("R8 resume from new address");
    rreg(3'd1, v); check(v == 32'h150, "R8 fetch after rewrite", v, 32'h150);

    // Disable mid-run
    for (int i = 0; i < 8; i++) put_w(42 + i, 32'h2000 + 4 * i, 32'h100 + i, 1);
    put_w(50, SC, 4, 0);
    cnt0 = obs_n;
    idx = 4; wreg(3'd3, idx);
    repeat (4) @(posedge clk);
    wreg(3'd0, 32'hA);
    for (int k = 0; k < 50; k++) begin rreg(3'd5, v); if (!v[0]) break; end
    nent = obs_n - cnt0;
    check(nent < 8, "R6 stopped early", nent, 8);
    rreg(3'd1, v); check(v == 32'h150 + 8 * nent, "R6 boundary kept", v, 32'h150 + 8 * nent);
    repeat (20) @(posedge clk);
    check(obs_n - cnt0 == nent, "R6 no writes while disabled", obs_n - cnt0, nent);
    wreg(3'd0, 32'hB);
    wait_bit(2);
    check_log("R6 resume after enable");

    // External pause
    for (int i = 0; i < 4; i++) put_w(51 + i, 32'h3000 + 4 * i, 32'h200 + i, 1);
    put_w(55, SC, 5, 0);
    pause_req = 1'b1;
    cnt0 = obs_n;
    idx = 5; wreg(3'd3, idx);
    repeat (20) @(posedge clk);
    check(obs_n == cnt0, "R9 held by pause input", obs_n, cnt0);
    rreg(3'd5, v); check(v[2] == 1'b1, "R9 paused flag", v, 4);
    @(negedge clk); pause_req = 1'b0;
    repeat (2) @(posedge clk);
    wait_bit(2);
    check_log("R9 continue after release");

    // Fetch error
    bad_faddr = 32'h1C0;
    put_w(56, 32'h0000_1030, 32'hE, 0);
    put_w(57, SC, 6, 0);
    cnt0 = obs_n;
    idx = 6; wreg(3'd3, idx);
    wait_bit(1);
    repeat (10) @(posedge clk);
    rreg(3'd5, v); check(v[1:0] == 2'b10, "R10 error halts", v, 2);
    rreg(3'd1, v); check(v == 32'h1C0, "R10 fetch not consumed", v, 32'h1C0);
    check(obs_n == cnt0, "R10 no write on fetch error", obs_n, cnt0);
    bad_faddr = 32'hFFFF_FFF0;
    exp_a[exp_n] = 32'h1030; exp_d[exp_n] = 32'hE; exp_n++;
    wreg(3'd0, 32'hA); wreg(3'd5, 32'h2); wreg(3'd0, 32'hB);
    wait_bit(2);
    check_log("R10 retry after clear");

    // Write error: first entry consumed, second carried out after recovery
    bad_waddr = 32'h1040;
    put_w(58, 32'h0000_1040, 32'hF, 0);
    put_w(59, 32'h0000_1044, 32'h11, 1);
    put_w(60, SC, 7, 0);
    idx = 7; wreg(3'd3, idx);
    wait_bit(1);
    rreg(3'd1, v); check(v == 32'h1D8, "R10 write error position", v, 32'h1D8);
    bad_waddr = 32'hFFFF_FFF0;
    wreg(3'd0, 32'hA); wreg(3'd5, 32'h2); wreg(3'd0, 32'hB);
    wait_bit(2);
    check_log("R10 write error recovery");

    // Random batches over a wrapping ring
    ptr = 61;
    for (int r = 0; r < 10; r++) begin
      if (ptr > 56) begin
        put_w(ptr, SF, 0, 0);
        ptr = 0;
      end
      nent = 1 + $urandom % 5;
      for (int i = 0; i < nent; i++) begin
        put_w(ptr, 32'h4000 + 4 * ($urandom % 256) + ($urandom % 2), $urandom, 1);
        ptr++;
      end
      idx++;
      put_w(ptr, SC | ($urandom % 2), idx, 0);
      ptr++;
      wreg(3'd3, idx);
      wait_bit(2);
      check_log("R1 random batch");
      rreg(3'd1, v); check(v == ptr * 8, "R3 random fetch position", v, ptr * 8);
      rreg(3'd2, v); check(v == idx, "R4 random index", v, idx);
      check(irq_n == exp_irq, "R2 random pulses", irq_n, exp_irq);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule